// File: doc/BRIEF.md
# Flash Busy Status Reporter

This block stands in front of a NOR-style flash array and decides what a read returns while an internally timed program or erase is in progress. It records whether an operation is running, which kind it is, and the data word handed to the last accepted program. An external timer model signals when the operation has finished.

While the operation runs, every read returns a status word instead of array contents. Bit 7 carries a polarity flag. It is the inverse of the loaded bit 7 during a program and 0 during an erase. Bit 6 changes value on each read, so software can tell that the part is busy. Once the timer reports completion, reads return the array word supplied on `array_data` again.

A read is requested by raising `rd_req`. Only the rising edge counts. The answer appears one clock later, together with a one-cycle `rd_valid` pulse. The response has no ready signal and no back-pressure: the consumer must take the word in the cycle `rd_valid` is high. A new read needs `rd_req` to fall and rise again.

Top module: `flash_busy_status`

## Requirements
- R1: With no operation running, a read returns `array_data`, as sampled at the strobe edge, on all 16 bits. It appears on `rd_data` one clock after the edge that samples the rising `rd_req`, with `rd_valid` high for exactly that one cycle.
- R2: During a program, a read returns loaded bits 15..8 and 5..0 unchanged and the complement of loaded bit 7 on bit 7.
- R3: During an erase, a read returns 0 on every bit except bit 6.
- R4: During any operation, bit 6 of the first read after the start is 0. Bit 6 then inverts on each further read of that operation.
- R5: A pulse on `op_done` ends the operation. Every later read returns array data, and bit 6 no longer alternates.
- R6: A `prog_start` or `erase_start` that arrives while an operation runs is ignored. Neither the loaded data nor the kind of operation changes.
- R7: Only a rising edge of `rd_req` is a read. Holding `rd_req` high gives one response, and clocks without a read do not advance bit 6.
- R8: An active-low `rst_n` asynchronously ends any operation and clears the bit 6 state, `rd_valid` and `rd_data`.
- R9: When `prog_start` and `erase_start` arrive in the same idle cycle, the program is taken.
- R10: A read whose strobe edge coincides with a start is judged against the idle state. A read whose strobe edge coincides with `op_done` is judged against the busy state. The next read after a start is already a status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_start | input | 1 | One-cycle pulse that starts a word program |
| prog_data | input | 16 | Data word loaded with the program |
| erase_start | input | 1 | One-cycle pulse that starts an erase |
| op_done | input | 1 | Completion pulse from the external timer model |
| rd_req | input | 1 | Read request; its rising edge is a read |
| array_data | input | 16 | True array word for the address being read |
| rd_valid | output | 1 | One-cycle pulse marking a returned word |
| rd_data | output | 16 | Returned read word |

## Verification
The hardest cases to reach are the collisions, where a read edge lands in the very cycle that a start or a completion pulse arrives. In those cycles the answer depends only on the state before that clock edge. The bench drives both inputs at the same falling edge, so they share one sampling clock edge, and checks the word on either side of the change. It also holds `rd_req` high across several clocks and leaves idle gaps between reads, to show that bit 6 follows read edges and not the clock. The program path is swept over walking-one and walking-zero data words.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2
  } op_e;
endpackage

// File: rtl/flash_rd_edge.sv
module flash_rd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic strobe_o
);
  logic req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_i;
  end

  assign strobe_o = req_i & ~req_q;
endmodule

// File: rtl/flash_op_track.sv
module flash_op_track
  import flash_stat_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_start_i,
  input  logic [DW-1:0] prog_data_i,
  input  logic          erase_start_i,
  input  logic          done_i,
  input  logic          strobe_i,
  output op_e           op_o,
  output logic [DW-1:0] ld_o,
  output logic          tgl_o
);
  op_e           op_q;
  logic [DW-1:0] ld_q;
  logic          tgl_q;
  logic          idle;
  logic          take_prog;
  logic          take_erase;

  assign idle       = (op_q == OP_IDLE);
  // program wins over erase when both arrive in one idle cycle
  assign take_prog  = idle & prog_start_i;
  assign take_erase = idle & erase_start_i & ~prog_start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= OP_IDLE;
    end else if (take_prog) begin
      op_q <= OP_PROG;
    end else if (take_erase) begin
      op_q <= OP_ERASE;
    end else if (!idle && done_i) begin
      op_q <= OP_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ld_q <= '0;
    else if (take_prog) ld_q <= prog_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       tgl_q <= 1'b0;
    else if (take_prog || take_erase) tgl_q <= 1'b0;
    else if (strobe_i && !idle)       tgl_q <= ~tgl_q;
  end

  assign op_o  = op_q;
  assign ld_o  = ld_q;
  assign tgl_o = tgl_q;
endmodule

// File: rtl/flash_stat_fmt.sv
module flash_stat_fmt
  import flash_stat_pkg::*;
#(
  parameter int DW       = 16,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  op_e           op_i,
  input  logic [DW-1:0] ld_i,
  input  logic          tgl_i,
  input  logic [DW-1:0] array_i,
  output logic [DW-1:0] word_o
);
  localparam int LAST = DW - 1;

  logic [DW-1:0] stat_w;

  for (genvar b = 0; b <= LAST; b++) begin : g_bit
    if (b == POLL_BIT) begin : g_poll
      assign stat_w[b] = (op_i == OP_PROG) ? ~ld_i[b] : 1'b0;
    end else if (b == TOG_BIT) begin : g_tog
      assign stat_w[b] = tgl_i;
    end else begin : g_pass
      assign stat_w[b] = (op_i == OP_PROG) ? ld_i[b] : 1'b0;
    end
  end

  always_comb begin
    if (op_i == OP_IDLE) word_o = array_i;
    else                 word_o = stat_w;
  end
endmodule

// File: rtl/flash_busy_status.sv
module flash_busy_status
  import flash_stat_pkg::*;
#(
  parameter int DW       = 16,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_start,
  input  logic [DW-1:0] prog_data,
  input  logic          erase_start,
  input  logic          op_done,
  input  logic          rd_req,
  input  logic [DW-1:0] array_data,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  logic          rd_strobe;
  op_e           op_q;
  logic [DW-1:0] ld_q;
  logic          tgl_q;
  logic [DW-1:0] word_w;

  flash_rd_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (rd_req),
    .strobe_o (rd_strobe)
  );

  flash_op_track #(.DW(DW)) u_track (
    .clk           (clk),
    .rst_n         (rst_n),
    .prog_start_i  (prog_start),
    .prog_data_i   (prog_data),
    .erase_start_i (erase_start),
    .done_i        (op_done),
    .strobe_i      (rd_strobe),
    .op_o          (op_q),
    .ld_o          (ld_q),
    .tgl_o         (tgl_q)
  );

  flash_stat_fmt #(.DW(DW), .POLL_BIT(POLL_BIT), .TOG_BIT(TOG_BIT)) u_fmt (
    .op_i    (op_q),
    .ld_i    (ld_q),
    .tgl_i   (tgl_q),
    .array_i (array_data),
    .word_o  (word_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_strobe;
      if (rd_strobe) rd_data <= word_w;
    end
  end
endmodule

// File: rtl/flash_busy_status_chk.sv
module flash_busy_status_chk
  import flash_stat_pkg::*;
#(
  parameter int DW       = 16,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_strobe,
  input op_e           op_q,
  input logic [DW-1:0] ld_q,
  input logic          tgl_q,
  input logic [DW-1:0] array_data,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data
);
  // R1
  idle_read_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && op_q == OP_IDLE) |=> (rd_valid && rd_data == $past(array_data)));

  // R7
  single_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R2
  prog_poll_inverted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && op_q == OP_PROG) |=> (rd_data[POLL_BIT] != ld_q[POLL_BIT]));

  // R3
  erase_poll_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && op_q == OP_ERASE) |=> (rd_data[POLL_BIT] == 1'b0));

  // R4
  toggle_flips_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && op_q != OP_IDLE) |=> (tgl_q != $past(tgl_q)));

  // R6
  load_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q != OP_IDLE) |=> $stable(ld_q));
endmodule

bind flash_busy_status flash_busy_status_chk #(
  .DW(DW), .POLL_BIT(POLL_BIT), .TOG_BIT(TOG_BIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_strobe  (rd_strobe),
  .op_q       (op_q),
  .ld_q       (ld_q),
  .tgl_q      (tgl_q),
  .array_data (array_data),
  .rd_valid   (rd_valid),
  .rd_data    (rd_data)
);

// File: tb/tb_flash_busy_status.sv
module tb_flash_busy_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_start = 1'b0;
  logic [15:0] prog_data = '0;
  logic        erase_start = 1'b0;
  logic        op_done = 1'b0;
  logic        rd_req = 1'b0;
  logic [15:0] array_data = '0;
  logic        rd_valid;
  logic [15:0] rd_data;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  flash_busy_status dut (
    .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .prog_data(prog_data),
    .erase_start(erase_start), .op_done(op_done), .rd_req(rd_req),
    .array_data(array_data), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] prog_word(input logic [15:0] d, input logic t);
    return {d[15:8], ~d[7], t, d[5:0]};
  endfunction

  task automatic start_prog(input logic [15:0] d);
    @(negedge clk); prog_start = 1'b1; prog_data = d;
    @(negedge clk); prog_start = 1'b0;
  endtask

  task automatic start_erase();
    @(negedge clk); erase_start = 1'b1;
    @(negedge clk); erase_start = 1'b0;
  endtask

  task automatic finish_op();
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
  endtask

  // one read: raise, sample after one edge, lower
  task automatic do_read(input string req, input logic [15:0] exp);
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk);
    chk(req, {15'd0, rd_valid}, 16'd1);
    chk(req, rd_data, exp);
    rd_req = 1'b0;
    @(negedge clk);
    chk(req, {15'd0, rd_valid}, 16'd0);
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    report();
    $finish;
  end

  initial begin
    logic [15:0] d;
    int vc;
    // R8 reset state
    #1;
    chk("R8 reset valid", {15'd0, rd_valid}, 16'd0);
    chk("R8 reset data", rd_data, 16'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 idle reads over walking patterns
    for (int i = 0; i < 16; i++) begin
      array_data = 16'h1 << i;
      do_read("R1 idle walk", 16'h1 << i);
    end
    array_data = 16'hA5C3;
    do_read("R1 idle mixed", 16'hA5C3);

    // R2 R4 R5 program sweep, walking ones and zeros
    for (int i = 0; i < 32; i++) begin
      d = (i < 16) ? (16'h1 << i) : ~(16'h1 << (i - 16));
      array_data = d ^ 16'hFFFF;
      start_prog(d);
      for (int r = 0; r < 3; r++)
        do_read("R2 R4 program status", prog_word(d, r[0]));
      finish_op();
      array_data = d;
      do_read("R5 after program", d);
      do_read("R5 stays array", d);
    end

    // R3 R4 erase
    array_data = 16'hFFFF;
    start_erase();
    for (int r = 0; r < 4; r++)
      do_read("R3 R4 erase status", r[0] ? 16'h0040 : 16'h0000);

    // R6 starts while busy are ignored
    @(negedge clk); prog_start = 1'b1; prog_data = 16'h1234;
    @(negedge clk); prog_start = 1'b0;
    do_read("R6 erase kept", 16'h0000);
    finish_op();
    do_read("R5 after erase", 16'hFFFF);

    start_prog(16'h00FF);
    @(negedge clk); erase_start = 1'b1;
    @(negedge clk); erase_start = 1'b0; prog_start = 1'b1; prog_data = 16'hFF00;
    @(negedge clk); prog_start = 1'b0;
    do_read("R6 program kept", prog_word(16'h00FF, 1'b0));
    finish_op();

    // R7 held request gives one response, idle clocks do not advance bit 6
    start_erase();
    @(negedge clk); rd_req = 1'b1;
    vc = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (rd_valid) vc++;
    end
    chk("R7 one response while held", vc[15:0], 16'd1);
    chk("R7 held read word", rd_data, 16'h0000);
    rd_req = 1'b0;
    repeat (6) @(negedge clk);
    do_read("R7 toggle after gap", 16'h0040);
    repeat (9) @(negedge clk);
    do_read("R7 toggle after second gap", 16'h0000);
    finish_op();

    // R9 simultaneous starts take the program
    @(negedge clk); prog_start = 1'b1; erase_start = 1'b1; prog_data = 16'h8001;
    @(negedge clk); prog_start = 1'b0; erase_start = 1'b0;
    do_read("R9 program wins", prog_word(16'h8001, 1'b0));
    finish_op();

    // R10 read edge in the start cycle sees idle, next read sees busy
    array_data = 16'h5A5A;
    @(negedge clk); rd_req = 1'b1; prog_start = 1'b1; prog_data = 16'h0F0F;
    @(negedge clk); prog_start = 1'b0;
    chk("R10 start cycle read", rd_data, 16'h5A5A);
    rd_req = 1'b0;
    do_read("R10 next read busy", prog_word(16'h0F0F, 1'b0));
    // R10 read edge in the done cycle sees busy
    @(negedge clk); rd_req = 1'b1; op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
    chk("R10 done cycle read", rd_data, prog_word(16'h0F0F, 1'b1));
    rd_req = 1'b0;
    do_read("R10 after done", 16'h5A5A);

    // R8 reset during an operation
    start_erase();
    do_read("R8 busy before reset", 16'h0000);
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R8 async clear data", rd_data, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    do_read("R8 idle after reset", 16'h5A5A);
    start_erase();
    do_read("R8 toggle cleared", 16'h0000);
    finish_op();

    report();
    $finish;
  end
endmodule